// File: doc/BRIEF.md
# Register-Pointer Slave for a Clock/RAM Device on I2C

This block is the register-access layer of an I2C slave that fronts a 64-byte register space. The bit-level bus engine hands it decoded events: START, repeated START, STOP, an address byte carrying the R/W flag, and data bytes. The block decides whether to acknowledge each byte and keeps the register pointer. It stores writes and supplies the byte the engine shifts out on reads.

Locations 0x00–0x07 belong to the timekeeping and control logic. Writes to them leave the block on a one-cycle write strobe. Reads of 0x00–0x06 come from a copy of the time taken when the read is accepted, so a seconds tick in the middle of a burst cannot mix old and new fields. Location 0x07 is read live. Locations 0x08–0x3F are general-purpose RAM held inside the block.

A write transaction carries the pointer in its first data byte, and every later byte is stored at the pointer. A read either follows the pointer byte through a repeated START or starts fresh at wherever the pointer was left. The pointer steps once per transferred byte and wraps from 0x3F to 0x00.

Top module: `rtc_reg_slave`

## Requirements
- R1: Only address byte bits [7:1] == 0x68 are acknowledged. Any other address gives ack_valid_o=1 with ack_o=0 and returns the block to idle. The data bytes that follow get no acknowledge pulse and change no storage.
- R2: ev_kind_i encodes 1=START, 2=repeated START, 3=STOP, 4=address (ev_byte_i bit 0 = 1 for read), 5=data. In a write transaction, the first data byte after the address loads the pointer from its low 6 bits and is acknowledged.
- R3: Each later data byte of a write is acknowledged and stored at the pointer. For 0x00–0x07 it is forwarded one cycle after the event on tk_we_o, tk_addr_o and tk_wdata_o. For 0x08–0x3F it goes to internal RAM, and tk_we_o stays 0.
- R4: A repeated START after the pointer byte, followed by a matching read address, is acknowledged. It raises tx_en_o, and tx_byte_o presents the byte at the pointer.
- R5: The pointer advances by one after every transferred data byte, in both directions, and wraps from 0x3F to 0x00.
- R6: In a read, a data event with mst_ack_i=0 (master NACK) ends output: tx_en_o drops to 0. The pointer still advances past that byte.
- R7: A START followed directly by a matching read address reads from the current pointer, without loading the pointer.
- R8: Bytes 0x00–0x06 of tk_regs_i are captured at the clock edge where a read address is accepted, and reads of those locations return the captured copy. Location 0x07 is read from tk_regs_i live.
- R9: Register 3 keeps only bits [2:0], and register 7 keeps only bits 7, 4, 1 and 0. The other bits are forced to zero on forwarded writes and on reads.
- R10: START from any state begins address reception. STOP returns to idle with tx_en_o=0. A repeated START outside the pointer-written state acts as START. A non-read address after a repeated START that follows the pointer byte is not acknowledged. Events in idle give no acknowledge and have no effect.
- R11: After reset, tx_en_o, ack_valid_o and tk_we_o are 0, the pointer is 0x00, and the RAM bytes read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | Bus event valid for one cycle |
| ev_kind_i | input | 3 | Event code (see R2) |
| ev_byte_i | input | 8 | Address or data byte of the event |
| mst_ack_i | input | 1 | Master acknowledge of a read byte (1 = ACK) |
| ack_valid_o | output | 1 | Acknowledge decision valid, one cycle after the event |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_en_o | output | 1 | Slave is driving read data |
| tx_byte_o | output | 8 | Byte to shift out next |
| tk_regs_i | input | 64 | Time/control bytes 0..7, byte n at bits [8n+7:8n] |
| tk_we_o | output | 1 | Write strobe to time/control logic |
| tk_addr_o | output | 3 | Time/control register index |
| tk_wdata_o | output | 8 | Masked write data |

## Verification
Capturing the time copy and a tick of the live time can fall on the same clock edge. The bench provokes this by changing tk_regs_i on the same cycle the read address is presented. It expects the copy to hold the value present at that edge, and changes the time again one cycle later. It then judges the burst by reading back locations 0, 1 and 3 and the live register 7 through tx_byte_o. Pointer wrap on writes and on reads is exercised in the same run.

// File: rtl/rtc_slv_pkg.sv
package rtc_slv_pkg;
  typedef enum logic [2:0] {
    EV_NONE = 3'd0, EV_START = 3'd1, EV_RSTART = 3'd2,
    EV_STOP = 3'd3, EV_ADDR = 3'd4, EV_DATA = 3'd5
  } ev_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GET_ADDR, ST_GET_PTR, ST_WRITE_DATA, ST_READ_ADDR, ST_READ_DATA
  } st_e;

  // bits that survive on time/control registers with reserved fields
  function automatic logic [7:0] keep_mask(input int idx);
    case (idx)
      3:       return 8'h07;
      7:       return 8'h93;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_slv_fsm.sv
module rtc_slv_fsm
  import rtc_slv_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h68
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ev_valid_i,
  input  logic [2:0] ev_kind_i,
  input  logic [7:0] ev_byte_i,
  input  logic       mst_ack_i,
  output st_e        state_o,
  output logic       ld_ptr_o,
  output logic       wr_en_o,
  output logic       rd_adv_o,
  output logic       snap_o,
  output logic       tx_live_o,
  output logic       ack_valid_o,
  output logic       ack_o
);
  st_e  st_q, st_d;
  logic live_q, live_d;
  logic ackv_q, ack_q, ackv_d, ack_d;
  logic is_start, is_rstart, is_stop, is_addr, is_data, hit, rw;

  assign is_start  = ev_valid_i && (ev_kind_i == EV_START);
  assign is_rstart = ev_valid_i && (ev_kind_i == EV_RSTART);
  assign is_stop   = ev_valid_i && (ev_kind_i == EV_STOP);
  assign is_addr   = ev_valid_i && (ev_kind_i == EV_ADDR);
  assign is_data   = ev_valid_i && (ev_kind_i == EV_DATA);
  assign hit       = ev_byte_i[7:1] == SLAVE_ADDR;
  assign rw        = ev_byte_i[0];

  always_comb begin
    st_d     = st_q;
    ackv_d   = 1'b0;
    ack_d    = 1'b0;
    ld_ptr_o = 1'b0;
    wr_en_o  = 1'b0;
    rd_adv_o = 1'b0;
    snap_o   = 1'b0;
    if (is_start) begin
      st_d = ST_GET_ADDR;
    end else if (is_rstart) begin
      st_d = (st_q == ST_WRITE_DATA) ? ST_READ_ADDR : ST_GET_ADDR;
    end else if (is_stop) begin
      st_d = ST_IDLE;
    end else if (is_addr) begin
      case (st_q)
        ST_GET_ADDR: begin
          ackv_d = 1'b1;
          if (hit) begin
            ack_d  = 1'b1;
            snap_o = rw;
            st_d   = rw ? ST_READ_DATA : ST_GET_PTR;
          end else st_d = ST_IDLE;
        end
        ST_READ_ADDR: begin
          ackv_d = 1'b1;
          if (hit && rw) begin
            ack_d  = 1'b1;
            snap_o = 1'b1;
            st_d   = ST_READ_DATA;
          end else st_d = ST_IDLE;
        end
        default: ;
      endcase
    end else if (is_data) begin
      case (st_q)
        ST_GET_PTR: begin
          ackv_d = 1'b1; ack_d = 1'b1; ld_ptr_o = 1'b1; st_d = ST_WRITE_DATA;
        end
        ST_WRITE_DATA: begin
          ackv_d = 1'b1; ack_d = 1'b1; wr_en_o = 1'b1;
        end
        ST_READ_DATA: rd_adv_o = live_q;
        default: ;
      endcase
    end
  end

  always_comb begin
    live_d = live_q;
    if (snap_o) live_d = 1'b1;
    else if (rd_adv_o && !mst_ack_i) live_d = 1'b0;
    else if (is_start || is_rstart || is_stop) live_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      live_q <= 1'b0;
      ackv_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      live_q <= live_d;
      ackv_q <= ackv_d;
      ack_q  <= ack_d;
    end
  end

  assign state_o     = st_q;
  assign tx_live_o   = live_q;
  assign ack_valid_o = ackv_q;
  assign ack_o       = ack_q;
endmodule

// File: rtl/rtc_slv_ptr.sv
module rtc_slv_ptr #(
  parameter int PTR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] ld_val_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;

  // power-of-two space: natural rollover gives the wrap to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (ld_i)  ptr_q <= ld_val_i;
    else if (inc_i) ptr_q <= ptr_q + PTR_W'(1);
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rtc_slv_regs.sv
module rtc_slv_regs
  import rtc_slv_pkg::*;
#(
  parameter int SPACE     = 64,
  parameter int TK_REGS   = 8,
  parameter int SNAP_REGS = 7,
  parameter int PTR_W     = $clog2(SPACE),
  parameter int TKA_W     = $clog2(TK_REGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic                 wr_en_i,
  input  logic [7:0]           wdata_i,
  input  logic                 snap_i,
  input  logic [TK_REGS*8-1:0] tk_regs_i,
  output logic [7:0]           rd_byte_o,
  output logic                 tk_we_o,
  output logic [TKA_W-1:0]     tk_addr_o,
  output logic [7:0]           tk_wdata_o
);
  localparam logic [PTR_W-1:0] TK_LIM = PTR_W'(TK_REGS);

  logic [7:0] ram_q  [TK_REGS:SPACE-1];
  logic [7:0] snap_q [SNAP_REGS];
  logic [7:0] view   [TK_REGS];
  logic       is_tk;

  assign is_tk = ptr_i < TK_LIM;

  for (genvar g = 0; g < TK_REGS; g++) begin : g_view
    if (g < SNAP_REGS) begin : g_snap
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     snap_q[g] <= '0;
        else if (snap_i) snap_q[g] <= tk_regs_i[g*8 +: 8];
      end
      assign view[g] = snap_q[g] & keep_mask(g);
    end else begin : g_live
      assign view[g] = tk_regs_i[g*8 +: 8] & keep_mask(g);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = TK_REGS; i < SPACE; i++) ram_q[i] <= '0;
    end else if (wr_en_i && !is_tk) begin
      ram_q[ptr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tk_we_o    <= 1'b0;
      tk_addr_o  <= '0;
      tk_wdata_o <= '0;
    end else begin
      tk_we_o <= wr_en_i && is_tk;
      if (wr_en_i && is_tk) begin
        tk_addr_o  <= ptr_i[TKA_W-1:0];
        tk_wdata_o <= wdata_i & keep_mask(int'(ptr_i));
      end
    end
  end

  assign rd_byte_o = is_tk ? view[ptr_i[TKA_W-1:0]] : ram_q[ptr_i];
endmodule

// File: rtl/rtc_reg_slave.sv
module rtc_reg_slave
  import rtc_slv_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h68,
  parameter int SPACE     = 64,
  parameter int TK_REGS   = 8,
  parameter int SNAP_REGS = 7,
  localparam int PTR_W    = $clog2(SPACE),
  localparam int TKA_W    = $clog2(TK_REGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ev_valid_i,
  input  logic [2:0]           ev_kind_i,
  input  logic [7:0]           ev_byte_i,
  input  logic                 mst_ack_i,
  output logic                 ack_valid_o,
  output logic                 ack_o,
  output logic                 tx_en_o,
  output logic [7:0]           tx_byte_o,
  input  logic [TK_REGS*8-1:0] tk_regs_i,
  output logic                 tk_we_o,
  output logic [TKA_W-1:0]     tk_addr_o,
  output logic [7:0]           tk_wdata_o
);
  st_e              state;
  logic             ld_ptr, wr_en, rd_adv, snap, tx_live, ptr_step;
  logic [PTR_W-1:0] ptr_q;

  rtc_slv_fsm #(.SLAVE_ADDR(SLAVE_ADDR)) u_fsm (
    .clk_i, .rst_ni, .ev_valid_i, .ev_kind_i, .ev_byte_i, .mst_ack_i,
    .state_o(state), .ld_ptr_o(ld_ptr), .wr_en_o(wr_en), .rd_adv_o(rd_adv),
    .snap_o(snap), .tx_live_o(tx_live), .ack_valid_o, .ack_o
  );

  assign ptr_step = wr_en || rd_adv;

  rtc_slv_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i, .rst_ni, .ld_i(ld_ptr), .ld_val_i(ev_byte_i[PTR_W-1:0]),
    .inc_i(ptr_step), .ptr_o(ptr_q)
  );

  rtc_slv_regs #(
    .SPACE(SPACE), .TK_REGS(TK_REGS), .SNAP_REGS(SNAP_REGS),
    .PTR_W(PTR_W), .TKA_W(TKA_W)
  ) u_regs (
    .clk_i, .rst_ni, .ptr_i(ptr_q), .wr_en_i(wr_en), .wdata_i(ev_byte_i),
    .snap_i(snap), .tk_regs_i, .rd_byte_o(tx_byte_o),
    .tk_we_o, .tk_addr_o, .tk_wdata_o
  );

  assign tx_en_o = (state == ST_READ_DATA) && tx_live;
endmodule

// File: rtl/rtc_slv_chk.sv
module rtc_slv_chk #(
  parameter logic [6:0] SLAVE_ADDR = 7'h68,
  parameter int PTR_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ev_valid_i,
  input logic [2:0]       ev_kind_i,
  input logic [7:0]       ev_byte_i,
  input logic             mst_ack_i,
  input logic             ack_o,
  input logic             tx_en_o,
  input logic [7:0]       tx_byte_o,
  input logic [PTR_W-1:0] ptr_i,
  input logic             step_i
);
  AST_FOREIGN_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && ev_kind_i == 3'd4 && ev_byte_i[7:1] != SLAVE_ADDR |=> !ack_o); // R1
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && ptr_i == '1 |=> ptr_i == '0); // R5
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && ptr_i != '1 |=> ptr_i == $past(ptr_i) + PTR_W'(1)); // R5
  AST_NACK_ENDS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o && ev_valid_i && ev_kind_i == 3'd5 && !mst_ack_i |=> !tx_en_o); // R6
  AST_RSV3_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o && ptr_i == PTR_W'(3) |-> tx_byte_o[7:3] == 5'd0); // R9
  AST_RSV7_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o && ptr_i == PTR_W'(7) |-> (tx_byte_o & 8'h6C) == 8'h00); // R9
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && ev_kind_i == 3'd3 |=> !tx_en_o); // R10
endmodule

bind rtc_reg_slave rtc_slv_chk #(.SLAVE_ADDR(SLAVE_ADDR), .PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ev_valid_i(ev_valid_i), .ev_kind_i(ev_kind_i),
  .ev_byte_i(ev_byte_i), .mst_ack_i(mst_ack_i), .ack_o(ack_o), .tx_en_o(tx_en_o),
  .tx_byte_o(tx_byte_o), .ptr_i(ptr_q), .step_i(ptr_step)
);

// File: tb/rtc_reg_slave_bench.sv
`timescale 1ns/1ps
module rtc_reg_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_kind = 3'd0;
  logic [7:0]  ev_byte = 8'h00;
  logic        mst_ack = 1'b0;
  logic [63:0] tk = 64'h0;
  logic        ack_valid, ack, tx_en, tk_we;
  logic [7:0]  tx_byte, tk_wdata;
  logic [2:0]  tk_addr;

  typedef struct { logic ack; string tag; } exp_t;
  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_reg_slave u_rtc_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_kind_i(ev_kind),
    .ev_byte_i(ev_byte), .mst_ack_i(mst_ack), .ack_valid_o(ack_valid), .ack_o(ack),
    .tx_en_o(tx_en), .tx_byte_o(tx_byte), .tk_regs_i(tk), .tk_we_o(tk_we),
    .tk_addr_o(tk_addr), .tk_wdata_o(tk_wdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: every acknowledge pulse must match the next scoreboard entry
  always @(negedge clk) begin
    if (rst_n && ack_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected ack act=%b exp=none", ack);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (ack !== e.ack) begin
          n_bad++;
          $display("FAIL %s ack act=%b exp=%b", e.tag, ack, e.ack);
        end
      end
    end
  end

  task automatic drive(input logic [2:0] k, input logic [7:0] b, input logic m);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_byte = b; mst_ack = m;
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 3'd0;
  endtask

  task automatic push(input logic a, input string tag);
    exp_t e;
    e.ack = a; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic start();  drive(3'd1, 8'h00, 1'b0); endtask
  task automatic rstart(); drive(3'd2, 8'h00, 1'b0); endtask
  task automatic stop();   drive(3'd3, 8'h00, 1'b0); endtask
  task automatic addr(input logic [6:0] a, input logic rw, input logic a_exp, input string tag);
    push(a_exp, tag);
    drive(3'd4, {a, rw}, 1'b0);
  endtask
  task automatic wbyte(input logic [7:0] b, input string tag);
    push(1'b1, tag);
    drive(3'd5, b, 1'b0);
  endtask
  task automatic rbyte(input logic m); drive(3'd5, 8'h00, m); endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 tx_en reset", {7'd0, tx_en}, 8'h00);
    chk("R11 ack_valid reset", {7'd0, ack_valid}, 8'h00);
    chk("R11 tk_we reset", {7'd0, tk_we}, 8'h00);
    rst_n = 1'b1;

    // R2 R3: pointer load then RAM writes
    start(); addr(7'h68, 1'b0, 1'b1, "R1 own addr");
    wbyte(8'h10, "R2 ptr byte");
    wbyte(8'hAA, "R3 wr");
    chk("R3 RAM write no tk strobe", {7'd0, tk_we}, 8'h00);
    wbyte(8'hBB, "R3 wr"); wbyte(8'hCC, "R3 wr"); wbyte(8'hDD, "R3 wr");
    stop();

    // R1: foreign slave, following data must be ignored
    start(); addr(7'h50, 1'b0, 1'b0, "R1 foreign addr");
    drive(3'd5, 8'h12, 1'b0); drive(3'd5, 8'h77, 1'b0);
    stop();

    // R4 R5 R6: read after repeated start
    start(); addr(7'h68, 1'b0, 1'b1, "R4 addr");
    wbyte(8'h10, "R2 ptr byte");
    rstart(); addr(7'h68, 1'b1, 1'b1, "R4 read addr");
    chk("R4 tx_en", {7'd0, tx_en}, 8'h01);
    chk("R4 first byte", tx_byte, 8'hAA);
    rbyte(1'b1); chk("R5 next byte", tx_byte, 8'hBB);
    rbyte(1'b1); chk("R1 foreign data not stored", tx_byte, 8'hCC);
    rbyte(1'b0); chk("R6 nack ends tx", {7'd0, tx_en}, 8'h00);
    stop();

    // R7: fresh read at current pointer (advanced past nacked byte)
    start(); addr(7'h68, 1'b1, 1'b1, "R7 read addr");
    chk("R7 R6 fresh read at 0x13", tx_byte, 8'hDD);
    rbyte(1'b0); stop();
    chk("R10 stop clears tx", {7'd0, tx_en}, 8'h00);

    // R5 R3: write wrap into the forwarded range
    start(); addr(7'h68, 1'b0, 1'b1, "R5 addr");
    wbyte(8'h3F, "R2 ptr byte");
    wbyte(8'h11, "R5 wr 0x3F");
    wbyte(8'h22, "R5 wr wrapped");
    chk("R5 wrap tk_we", {7'd0, tk_we}, 8'h01);
    chk("R5 wrap tk_addr", {5'd0, tk_addr}, 8'h00);
    chk("R3 tk_wdata", tk_wdata, 8'h22);
    stop();

    // R8: capture coincides with a time change at the same edge
    tk[31:24] = 8'hFF; tk[63:56] = 8'h80;
    start(); addr(7'h68, 1'b0, 1'b1, "R8 addr");
    wbyte(8'h3F, "R2 ptr byte");
    rstart();
    push(1'b1, "R8 read addr");
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = 3'd4; ev_byte = {7'h68, 1'b1};
    tk[7:0] = 8'h45; tk[15:8] = 8'h12;
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 3'd0;
    tk[15:8] = 8'h59; tk[63:56] = 8'h81;
    chk("R5 read 0x3F", tx_byte, 8'h11);
    rbyte(1'b1); chk("R5 R8 read wraps to reg0", tx_byte, 8'h45);
    rbyte(1'b1); chk("R8 reg1 from capture", tx_byte, 8'h12);
    rbyte(1'b1); rbyte(1'b1);
    chk("R9 reg3 reserved read zero", tx_byte, 8'h07);
    rbyte(1'b1); rbyte(1'b1); rbyte(1'b1); rbyte(1'b1);
    chk("R8 R9 reg7 live masked", tx_byte, 8'h81);
    rbyte(1'b0); stop();

    // R9: reserved bits dropped on forwarded writes
    start(); addr(7'h68, 1'b0, 1'b1, "R9 addr");
    wbyte(8'h03, "R2 ptr byte");
    wbyte(8'hFF, "R9 wr reg3");
    chk("R9 reg3 addr", {5'd0, tk_addr}, 8'h03);
    chk("R9 reg3 data", tk_wdata, 8'h07);
    wbyte(8'h00, "R3 wr"); wbyte(8'h00, "R3 wr"); wbyte(8'h00, "R3 wr");
    wbyte(8'hFF, "R9 wr reg7");
    chk("R9 reg7 addr", {5'd0, tk_addr}, 8'h07);
    chk("R9 reg7 data", tk_wdata, 8'h93);
    stop();

    // R10: write-direction address after repeated start is refused
    start(); addr(7'h68, 1'b0, 1'b1, "R10 addr");
    wbyte(8'h20, "R2 ptr byte"); wbyte(8'h5A, "R3 wr"); stop();
    start(); addr(7'h68, 1'b0, 1'b1, "R10 addr");
    wbyte(8'h20, "R2 ptr byte");
    rstart(); addr(7'h68, 1'b0, 1'b0, "R10 write addr after rstart");
    drive(3'd5, 8'h99, 1'b0);
    start(); addr(7'h68, 1'b1, 1'b1, "R10 restart read");
    chk("R10 idle data ignored", tx_byte, 8'h5A);
    rbyte(1'b0); stop();

    repeat (3) @(negedge clk);
    chk("R1 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule